// File: doc/BRIEF.md
# Prioritized Pending-Interrupt Arbiter

This block keeps one pending bit for each of fourteen interrupt sources and, when the core asks for it, delivers the most urgent source that the current processor state allows. The priority order is fixed, but the masking is not uniform. Reset and machine check always pass. The hypervisor decrementer and the external input have their own conditions that depend on the mode bits. The critical external input follows only the critical-enable bit. The rest follow the external-enable bit. A delivery shows as a one-cycle `take_o` pulse with the source's index on `cause_o`. The same clock edge clears the source's pending bit, unless that source stays pending after delivery.

The core raises `step_req_i` for each arbitration step. It watches `any_pending_o` to decide whether a step is worth asking for. Sources post requests through `src_set_i` and withdraw them through `src_clr_i`. Entering a power-save state through `pwr_save_i` discards a waiting hypervisor-decrementer request.

Control is a three-state machine:
- **ST_EMPTY**: nothing is pending.
- **ST_ARMED**: at least one bit is pending and no delivery was made on the last edge.
- **ST_TAKE**: a delivery was made on the last edge.

Its transitions:
- ST_EMPTY goes to ST_ARMED when a bit becomes pending.
- ST_ARMED goes to ST_TAKE on a grant.
- ST_ARMED goes to ST_EMPTY when the register drains without a grant.
- ST_TAKE goes back to ST_ARMED or ST_EMPTY, depending on whether anything is still pending. It never grants again directly.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, no bit is pending, `take_o` is low, `cause_o` is 0, `any_pending_o` is low and the state is ST_EMPTY.
- R2: Source indices in priority order are: 0 reset, 1 machine check, 2 hypervisor decrementer, 3 external, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable timer, 9 decrementer, 10 doorbell, 11 hypervisor doorbell, 12 performance monitor, 13 thermal. The lowest eligible index wins, and `cause_o` carries that index.
- R3: `step_req_i` is sampled at a clock edge. If a source is eligible, `take_o` is high for exactly the next cycle. No grant is made at the edge that ends a ST_TAKE cycle, even with `step_req_i` high, and a grant never happens without a request.
- R4: Reset and machine check are delivered whatever the enable bits are, and their pending bit clears on delivery.
- R5: The hypervisor decrementer is eligible only when `hdec_en_i` = 1 and either `ee_i` = 1 or `hv_i` = 0. It clears on delivery.
- R6: The external source is eligible when `ee_i` = 1, or when `has_hv_i` = 1, `hv_i` = 0 and `ext_guest_i` = 0. It stays pending after delivery.
- R7: The critical external source is eligible only when `ce_i` = 1, and it stays pending after delivery.
- R8: Sources 5–8 and 10–13 are eligible only when `ee_i` = 1, and each clears on delivery.
- R9: The decrementer is eligible only when `ee_i` = 1. It clears on delivery only when `dec_cod_i` = 1.
- R10: A `pwr_save_i` cycle discards a pending hypervisor decrementer request and leaves the other bits untouched.
- R11: A set strobe wins over a clear strobe and over a delivery clear in the same cycle, so the bit stays pending.
- R12: A clear strobe alone removes the bit at the next edge.
- R13: `any_pending_o` is high exactly when the pending register is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set_i | input | 14 | Per-source request strobes |
| src_clr_i | input | 14 | Per-source withdraw strobes |
| step_req_i | input | 1 | Arbitration step request from the core |
| ee_i | input | 1 | External-enable state bit |
| ce_i | input | 1 | Critical-enable state bit |
| hv_i | input | 1 | Hypervisor state bit |
| hdec_en_i | input | 1 | Hypervisor decrementer enable |
| ext_guest_i | input | 1 | 1: external input belongs to the guest and is masked by EE |
| has_hv_i | input | 1 | Strap: a hypervisor mode exists |
| dec_cod_i | input | 1 | Decrementer clears on delivery |
| pwr_save_i | input | 1 | Power-save entry strobe |
| take_o | output | 1 | One-cycle delivery pulse |
| cause_o | output | 4 | Index of the delivered source |
| any_pending_o | output | 1 | Pending register is non-zero |

## Verification
The assertions assume that every input is synchronous and settles between edges. They also assume that the mode bits sampled at the requesting edge are the ones that justify a delivery, since the gating checks look back one cycle at `ee_i`, `ce_i`, `hv_i` and `hdec_en_i`. The stimulus changes mode bits, strobes and the request only on falling edges, and a mode bit never changes in the same cycle as the request it is meant to gate. Reset is held across several rising edges before the first stimulus.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;

    localparam int NUM_SRC = 14;
    localparam int CAUSE_W = $clog2(NUM_SRC);

    // Index order is the priority order: lower index wins.
    typedef enum logic [CAUSE_W-1:0] {
        SRC_RST  = 4'd0,
        SRC_MCHK = 4'd1,
        SRC_HDEC = 4'd2,
        SRC_EXT  = 4'd3,
        SRC_CEXT = 4'd4,
        SRC_WDOG = 4'd5,
        SRC_CDBL = 4'd6,
        SRC_FIT  = 4'd7,
        SRC_PIT  = 4'd8,
        SRC_DEC  = 4'd9,
        SRC_DBL  = 4'd10,
        SRC_HDBL = 4'd11,
        SRC_PERF = 4'd12,
        SRC_THRM = 4'd13
    } src_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ARMED = 2'd1,
        ST_TAKE  = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic ee;
        logic ce;
        logic hv;
        logic hdec_en;
        logic ext_guest;
        logic has_hv;
        logic dec_cod;
    } mode_t;

endpackage

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
module irq_pend_bank #(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] taken_i,
    input  logic [N-1:0] discard_i,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] pend_nx
);

    // A set strobe overrides every way of removing the bit.
    for (genvar k = 0; k < N; k++) begin : g_bit
        assign pend_nx[k] = set_i[k] |
                            (pend_q[k] & ~clr_i[k] & ~taken_i[k] & ~discard_i[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nx;
    end

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

    p_clear_drops_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

    p_discard_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(discard_i & ~set_i)) |=> ((pend_q & $past(discard_i & ~set_i)) == '0));

endmodule

// File: rtl/irq_gate.sv
`timescale 1ns/1ps
module irq_gate
    import irq_arb_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] pend_i,
    input  mode_t        mode_i,
    output logic [N-1:0] elig_o,
    output logic [N-1:0] drop_o
);

    // Per-source eligibility and clear-on-delivery rule.
    for (genvar k = 0; k < N; k++) begin : g_src
        if (k == int'(SRC_RST) || k == int'(SRC_MCHK)) begin : g_nomask
            assign elig_o[k] = pend_i[k];
            assign drop_o[k] = 1'b1;
        end else if (k == int'(SRC_HDEC)) begin : g_hdec
            assign elig_o[k] = pend_i[k] & mode_i.hdec_en & (mode_i.ee | ~mode_i.hv);
            assign drop_o[k] = 1'b1;
        end else if (k == int'(SRC_EXT)) begin : g_ext
            assign elig_o[k] = pend_i[k] &
                               (mode_i.ee | (mode_i.has_hv & ~mode_i.hv & ~mode_i.ext_guest));
            assign drop_o[k] = 1'b0;
        end else if (k == int'(SRC_CEXT)) begin : g_cext
            assign elig_o[k] = pend_i[k] & mode_i.ce;
            assign drop_o[k] = 1'b0;
        end else if (k == int'(SRC_DEC)) begin : g_dec
            assign elig_o[k] = pend_i[k] & mode_i.ee;
            assign drop_o[k] = mode_i.dec_cod;
        end else begin : g_ee
            assign elig_o[k] = pend_i[k] & mode_i.ee;
            assign drop_o[k] = 1'b1;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
    parameter int N = 14,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req_i,
    output logic         hit_o,
    output logic [W-1:0] idx_o,
    output logic [N-1:0] onehot_o
);

    // Scan from the lowest priority upward so the lowest index is written last.
    always_comb begin
        idx_o    = '0;
        onehot_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req_i[k]) begin
                idx_o       = W'(k);
                onehot_o    = '0;
                onehot_o[k] = 1'b1;
            end
        end
        hit_o = |req_i;
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
`timescale 1ns/1ps
module irq_prio_arbiter
    import irq_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_set_i,
    input  logic [NUM_SRC-1:0] src_clr_i,
    input  logic               step_req_i,
    input  logic               ee_i,
    input  logic               ce_i,
    input  logic               hv_i,
    input  logic               hdec_en_i,
    input  logic               ext_guest_i,
    input  logic               has_hv_i,
    input  logic               dec_cod_i,
    input  logic               pwr_save_i,
    output logic               take_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               any_pending_o
);

    localparam int N = NUM_SRC;

    arb_state_e           state_q, state_d;
    mode_t                mode;
    logic [N-1:0]         pend_q, pend_nx, elig, drop, pick_oh, taken, discard;
    logic [CAUSE_W-1:0]   pick_idx, cause_q;
    logic                 hit, grant;

    always_comb begin
        mode.ee        = ee_i;
        mode.ce        = ce_i;
        mode.hv        = hv_i;
        mode.hdec_en   = hdec_en_i;
        mode.ext_guest = ext_guest_i;
        mode.has_hv    = has_hv_i;
        mode.dec_cod   = dec_cod_i;
    end

    irq_gate #(.N(N)) u_gate (
        .pend_i (pend_q),
        .mode_i (mode),
        .elig_o (elig),
        .drop_o (drop)
    );

    irq_prio_pick #(.N(N), .W(CAUSE_W)) u_pick (
        .req_i    (elig),
        .hit_o    (hit),
        .idx_o    (pick_idx),
        .onehot_o (pick_oh)
    );

    // A request is honoured outside the cycle that follows a delivery.
    assign grant = step_req_i & hit & (state_q != ST_TAKE);

    always_comb begin
        taken            = grant ? (pick_oh & drop) : '0;
        discard          = '0;
        discard[SRC_HDEC] = pwr_save_i;
    end

    irq_pend_bank #(.N(N)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (src_set_i),
        .clr_i     (src_clr_i),
        .taken_i   (taken),
        .discard_i (discard),
        .pend_q    (pend_q),
        .pend_nx   (pend_nx)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (|pend_nx) state_d = ST_ARMED;
            ST_ARMED: begin
                if (grant)              state_d = ST_TAKE;
                else if (!(|pend_nx))   state_d = ST_EMPTY;
            end
            ST_TAKE:  state_d = (|pend_nx) ? ST_ARMED : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Cause capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cause_q <= '0;
        else if (grant) cause_q <= pick_idx;
    end

    // Outputs.
    always_comb begin
        take_o        = (state_q == ST_TAKE);
        cause_o       = cause_q;
        any_pending_o = |pend_q;
    end

    p_take_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    p_take_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(step_req_i));

    p_ee_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cause_o >= CAUSE_W'(SRC_WDOG)) |-> $past(ee_i));

    p_ce_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cause_o == CAUSE_W'(SRC_CEXT)) |-> $past(ce_i));

    p_hdec_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cause_o == CAUSE_W'(SRC_HDEC)) |->
            ($past(hdec_en_i) && ($past(ee_i) || !$past(hv_i))));

    p_ext_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cause_o == CAUSE_W'(SRC_EXT) && !$past(src_clr_i[SRC_EXT]))
            |-> pend_q[SRC_EXT]);

    p_armed_pending_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> any_pending_o);

endmodule

// File: tb/irq_prio_arbiter_test.sv
`timescale 1ns/1ps
module irq_prio_arbiter_test;
    import irq_arb_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] src_set = '0, src_clr = '0;
    logic step_req = 0, ee = 0, ce = 0, hv = 1, hdec_en = 0;
    logic ext_guest = 1, has_hv = 1, dec_cod = 0, pwr_save = 0;
    logic               take_o, any_pending_o;
    logic [CAUSE_W-1:0] cause_o;

    always #2.5 clk = ~clk;

    irq_prio_arbiter uut (
        .clk (clk), .rst_n (rst_n),
        .src_set_i (src_set), .src_clr_i (src_clr), .step_req_i (step_req),
        .ee_i (ee), .ce_i (ce), .hv_i (hv), .hdec_en_i (hdec_en),
        .ext_guest_i (ext_guest), .has_hv_i (has_hv), .dec_cod_i (dec_cod),
        .pwr_save_i (pwr_save),
        .take_o (take_o), .cause_o (cause_o), .any_pending_o (any_pending_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        bit    take;
        int    cause;
        string tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: the request seen at a rising edge is scored at the next falling edge.
    logic req_q = 1'b0;
    always @(posedge clk) req_q <= step_req;

    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n) begin
            if (req_q) begin
                if (sb.size() == 0) begin
                    check(0, "R3 scoreboard underflow", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check(take_o == e.take, e.tag, int'(take_o), int'(e.take));
                    if (e.take) check(int'(cause_o) == e.cause, e.tag, int'(cause_o), e.cause);
                end
            end else if (take_o) begin
                check(0, "R3 take without request", 1, 0);
            end
        end
    end

    task automatic push(bit t, int c, string tag);
        exp_t e;
        e.take = t; e.cause = c; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic request(bit t, int c, string tag);
        @(negedge clk);
        step_req = 1'b1;
        push(t, c, tag);
        @(negedge clk);
        step_req = 1'b0;
    endtask

    task automatic pulse_set(logic [NUM_SRC-1:0] m);
        @(negedge clk); src_set = m;
        @(negedge clk); src_set = '0;
    endtask

    task automatic pulse_clr(logic [NUM_SRC-1:0] m);
        @(negedge clk); src_clr = m;
        @(negedge clk); src_clr = '0;
    endtask

    task automatic check_pend(bit expv, string tag);
        check(any_pending_o == expv, tag, int'(any_pending_o), int'(expv));
    endtask

    function automatic logic [NUM_SRC-1:0] bitm(int k);
        logic [NUM_SRC-1:0] m = '0;
        m[k] = 1'b1;
        return m;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(take_o == 1'b0, "R1 take low", int'(take_o), 0);
        check(cause_o == '0, "R1 cause zero", int'(cause_o), 0);
        check_pend(0, "R1 nothing pending");

        // R8 / R13: thermal masked by EE, then delivered and cleared
        pulse_set(bitm(13));
        check_pend(1, "R13 any pending after set");
        request(0, 0, "R8 thermal masked by EE=0");
        ee = 1;
        request(1, 13, "R8 thermal delivered");
        check_pend(0, "R8 thermal cleared");
        ee = 0;

        // R4 / R2: reset and machine check ignore enables
        pulse_set(bitm(0) | bitm(1) | bitm(5));
        request(1, 0, "R4 reset first");
        request(1, 1, "R4 machine check with EE=0");
        request(0, 0, "R8 watchdog masked");
        ee = 1;
        request(1, 5, "R2 watchdog after enable");
        check_pend(0, "R4 all cleared");
        ee = 0;

        // R5: hypervisor decrementer gating
        pulse_set(bitm(2));
        ee = 1; hv = 1; hdec_en = 0;
        request(0, 0, "R5 disabled");
        hdec_en = 1; ee = 0;
        request(0, 0, "R5 EE=0 HV=1");
        hv = 0;
        request(1, 2, "R5 HV=0");
        check_pend(0, "R5 cleared on delivery");
        hdec_en = 0; hv = 1;

        // R6: external input routing, stays pending
        pulse_set(bitm(3));
        hv = 0; ext_guest = 0; has_hv = 1;
        request(1, 3, "R6 hypervisor route EE=0");
        check_pend(1, "R6 kept after delivery");
        request(1, 3, "R6 delivered again");
        ext_guest = 1;
        request(0, 0, "R6 guest route masked");
        ext_guest = 0; has_hv = 0;
        request(0, 0, "R6 no hypervisor mode");
        has_hv = 1; hv = 1;
        request(0, 0, "R6 HV=1 EE=0");
        ee = 1;
        request(1, 3, "R6 EE=1");
        ee = 0;
        pulse_clr(bitm(3));
        check_pend(0, "R12 clear strobe removes external");

        // R7: critical external
        pulse_set(bitm(4));
        ee = 1;
        request(0, 0, "R7 CE=0");
        ce = 1;
        request(1, 4, "R7 CE=1");
        check_pend(1, "R7 kept after delivery");
        pulse_set(bitm(3));
        request(1, 3, "R2 external over critical");
        pulse_clr(bitm(3));
        request(1, 4, "R7 critical after external withdrawn");
        pulse_clr(bitm(4));
        check_pend(0, "R12 clear critical");
        ce = 0; ee = 0;

        // R9: decrementer clear-on-delivery option
        pulse_set(bitm(9));
        ee = 1; dec_cod = 0;
        request(1, 9, "R9 delivered");
        check_pend(1, "R9 kept with dec_cod=0");
        dec_cod = 1;
        request(1, 9, "R9 delivered again");
        check_pend(0, "R9 cleared with dec_cod=1");
        ee = 0;

        // R10: power save discards hypervisor decrementer only
        pulse_set(bitm(2));
        check_pend(1, "R10 hdec pending");
        @(negedge clk); pwr_save = 1'b1;
        @(negedge clk); pwr_save = 1'b0;
        check_pend(0, "R10 hdec discarded");
        pulse_set(bitm(13));
        @(negedge clk); pwr_save = 1'b1;
        @(negedge clk); pwr_save = 1'b0;
        check_pend(1, "R10 other sources kept");
        pulse_clr(bitm(13));

        // R11: set wins over delivery clear and over clear strobe
        ee = 1;
        pulse_set(bitm(5));
        @(negedge clk);
        step_req = 1'b1; src_set = bitm(5);
        push(1, 5, "R11 watchdog delivered while re-set");
        @(negedge clk);
        step_req = 1'b0; src_set = '0;
        check_pend(1, "R11 set beat delivery clear");
        request(1, 5, "R11 watchdog again");
        check_pend(0, "R11 then cleared");
        @(negedge clk); src_set = bitm(6); src_clr = bitm(6);
        @(negedge clk); src_set = '0; src_clr = '0;
        check_pend(1, "R11 set beat clear strobe");
        pulse_clr(bitm(6));
        check_pend(0, "R12 clear strobe alone");

        // R3: back-to-back requests leave a gap after each delivery
        pulse_set(bitm(7) | bitm(8));
        @(negedge clk);
        step_req = 1'b1; push(1, 7, "R3 first of back-to-back");
        @(negedge clk);
        push(0, 0, "R3 no grant right after take");
        @(negedge clk);
        push(1, 8, "R3 grant after gap");
        @(negedge clk);
        step_req = 1'b0;
        check_pend(0, "R3 both cleared");

        // R2: full priority sweep
        hdec_en = 1; hv = 0; dec_cod = 1;
        pulse_set(bitm(2) | bitm(5) | bitm(6) | bitm(7) | bitm(8) | bitm(9) |
                  bitm(10) | bitm(11) | bitm(12) | bitm(13));
        request(1, 2, "R2 sweep hdec");
        for (int k = 5; k <= 13; k++) request(1, k, "R2 sweep order");
        check_pend(0, "R2 sweep drained");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R3 scoreboard empty", sb.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule